// File: doc/BRIEF.md
# Unaligned transmit buffer word packer

This block moves one transmit buffer from memory into a 32-bit transmit FIFO when the buffer may begin at any byte address and hold any number of bytes. For each buffer it issues whole-word reads. The reads start at the buffer address with its two low bits cleared and advance four bytes at a time. In the first word it drops the bytes that lie below the buffer start. In the last word it drops the bytes that lie past the buffer end. The bytes that remain are packed in address order into full FIFO words.

A small byte carry store holds up to seven bytes between reads. It lets the packer join bytes from two source words into one FIFO word. When a buffer is not the last of its frame, the one to three bytes left over stay in the carry store. They are placed at the front of the next buffer's data, so only the closing word of a frame can be partial. That word carries a last flag and a count of its valid bytes.

Reads use a request/acknowledge handshake with one read outstanding at a time. The data of each read comes back on a separate valid strobe at least one cycle after the acknowledge. A full FIFO stalls the output, and while the carry store holds a whole word no further read is requested.

Top module: `txp_packer`

## Requirements
- R1: After reset, `rd_req`, `fifo_wr` and `busy` are all low.
- R2: Every read address is word aligned (bits 1:0 are zero). A buffer's first read is at the start address with bits 1:0 cleared, and each following read is 4 bytes higher.
- R3: A buffer of length L at start address A issues exactly ((A mod 4) + L + 3) / 4 reads, with integer division. A buffer of length 0 issues none.
- R4: Byte lane k of `rd_rdata` and of `fifo_data` holds the byte at the lower address before lane k+1 (lane 0 is bits 7:0). The FIFO receives exactly the bytes of addresses A to A+L-1, in ascending address order, with no byte repeated.
- R5: Every FIFO write other than the last one of a frame has `fifo_bytes` = 4 and `fifo_last` = 0.
- R6: When `eof` was high at the start of a buffer, the frame's final FIFO write has `fifo_last` = 1 and `fifo_bytes` equal to the remaining byte count (1 to 4), and its unused upper lanes are zero.
- R7: When `eof` was low, the 0 to 3 bytes left after the last full word are kept and come out ahead of the next buffer's bytes. No write with `fifo_last` = 1 is made for that buffer.
- R8: `fifo_wr` is never high while `fifo_full` is high, and stalls of any length lose no byte.
- R9: Once raised, `rd_req` stays high with `rd_addr` unchanged until `rd_ack` is seen.
- R10: A `start` pulse while `busy` is high is ignored and does not change the read sequence or the FIFO data of the buffer in progress.
- R11: A start with length 0 and `eof` high flushes any bytes held in the carry store as the frame's final write.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a buffer; taken only while `busy` is low |
| start_addr | input | AW | Byte address of the first buffer byte |
| byte_len | input | LW | Number of bytes in the buffer |
| eof | input | 1 | Buffer closes its frame |
| busy | output | 1 | Buffer transfer or closing flush in progress |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Word-aligned read address |
| rd_ack | input | 1 | Read request accepted |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data word, little-endian lanes |
| fifo_full | input | 1 | FIFO cannot take a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | Packed word, lane 0 first |
| fifo_last | output | 1 | Final word of the frame |
| fifo_bytes | output | 3 | Valid bytes in this word (1 to 4) |

## Verification
The hardest case to reach from the ports is a carry store holding more than four bytes at the moment a FIFO stall starts. Reaching it also needs leftover bytes from an earlier buffer that did not end its frame, together with an offset read. The stimulus chains buffers that leave one to three leftover bytes and gives the next buffer a nonzero start offset. It then holds `fifo_full` high for long random stretches while acknowledges arrive at random. A scoreboard model tracks the same byte stream independently, and every FIFO word and every read address is compared against it.

// File: rtl/txp_pkg.sv
package txp_pkg;
  localparam int WORD_BYTES  = 4;
  localparam int CARRY_SLOTS = 2 * WORD_BYTES;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/txp_rd_ctrl.sv
module txp_rd_ctrl #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] byte_len,
  input  logic          space_ok,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic          rd_rvalid,
  output logic          rsp_valid,
  output logic [1:0]    rsp_lo,
  output logic [1:0]    rsp_hi,
  output logic          reads_done
);
  localparam int SW = LW + 2;

  logic [SW-1:0] span;
  logic [LW-1:0] words_w;
  logic [1:0]    tail_w;

  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] req_left_q, req_left_d;
  logic [LW-1:0] rsp_left_q, rsp_left_d;
  logic [LW-1:0] total_q, total_d;
  logic [1:0]    off_q, off_d, tail_q, tail_d;
  logic          outst_q, outst_d;

  assign span    = SW'(start_addr[1:0]) + SW'(byte_len) + SW'(3);
  assign words_w = span[SW-1:2];
  assign tail_w  = start_addr[1:0] + byte_len[1:0] - 2'd1;

  assign rd_req     = (req_left_q != '0) && !outst_q && space_ok;
  assign rd_addr    = addr_q;
  assign rsp_valid  = rd_rvalid && outst_q;
  assign rsp_lo     = (rsp_left_q == total_q) ? off_q : 2'd0;
  assign rsp_hi     = (rsp_left_q == LW'(1)) ? tail_q : 2'd3;
  assign reads_done = (req_left_q == '0) && (rsp_left_q == '0);

  always_comb begin
    addr_d     = addr_q;
    req_left_d = req_left_q;
    rsp_left_d = rsp_left_q;
    total_d    = total_q;
    off_d      = off_q;
    tail_d     = tail_q;
    outst_d    = outst_q;
    if (go) begin
      addr_d     = {start_addr[AW-1:2], 2'b00};
      req_left_d = words_w;
      rsp_left_d = words_w;
      total_d    = words_w;
      off_d      = start_addr[1:0];
      tail_d     = tail_w;
    end else begin
      if (rd_req && rd_ack) begin
        addr_d     = addr_q + AW'(4);
        req_left_d = req_left_q - LW'(1);
        outst_d    = 1'b1;
      end
      if (rsp_valid) begin
        outst_d    = 1'b0;
        rsp_left_d = rsp_left_q - LW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      req_left_q <= '0;
      rsp_left_q <= '0;
      total_q    <= '0;
      off_q      <= '0;
      tail_q     <= '0;
      outst_q    <= 1'b0;
    end else begin
      addr_q     <= addr_d;
      req_left_q <= req_left_d;
      rsp_left_q <= rsp_left_d;
      total_q    <= total_d;
      off_q      <= off_d;
      tail_q     <= tail_d;
      outst_q    <= outst_d;
    end
  end
endmodule

// File: rtl/txp_carry.sv
module txp_carry
  import txp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic [1:0]  in_lo,
  input  logic [1:0]  in_hi,
  input  logic        pop,
  output logic [3:0]  cnt,
  output logic [31:0] head
);
  byte_t      slot_q [CARRY_SLOTS];
  byte_t      slot_d [CARRY_SLOTS];
  logic [3:0] cnt_q, cnt_d, n_pop, cnt_mid, n_in;

  always_comb begin
    n_pop   = pop ? ((cnt_q >= 4'd4) ? 4'd4 : cnt_q) : 4'd0;
    cnt_mid = cnt_q - n_pop;
    n_in    = in_valid ? ({2'b00, in_hi} - {2'b00, in_lo} + 4'd1) : 4'd0;
    for (int j = 0; j < CARRY_SLOTS; j++) begin
      int src;
      int k;
      src = j + int'(n_pop);
      k   = j - int'(cnt_mid);
      slot_d[j] = (src < CARRY_SLOTS) ? slot_q[3'(src)] : 8'h00;
      if (in_valid && k >= 0 && k < int'(n_in))
        slot_d[j] = in_data[8*((int'(in_lo) + k) & 3) +: 8];
    end
    cnt_d = cnt_mid + n_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int j = 0; j < CARRY_SLOTS; j++) slot_q[j] <= 8'h00;
    end else begin
      cnt_q <= cnt_d;
      for (int j = 0; j < CARRY_SLOTS; j++) slot_q[j] <= slot_d[j];
    end
  end

  assign cnt = cnt_q;
  generate
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_head
      assign head[8*g +: 8] = slot_q[g];
    end
  endgenerate
endmodule

// File: rtl/txp_packer.sv
module txp_packer #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] byte_len,
  input  logic          eof,
  output logic          busy,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic          rd_rvalid,
  input  logic [31:0]   rd_rdata,
  input  logic          fifo_full,
  output logic          fifo_wr,
  output logic [31:0]   fifo_data,
  output logic          fifo_last,
  output logic [2:0]    fifo_bytes
);
  logic        accept, go, rsp_valid, reads_done, closing;
  logic [1:0]  rsp_lo, rsp_hi;
  logic [3:0]  cnt;
  logic [31:0] head;
  logic        eof_q, eof_d;

  assign accept = start && !busy;
  assign go     = accept && (byte_len != '0);

  txp_rd_ctrl #(.AW(AW), .LW(LW)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .start_addr (start_addr),
    .byte_len   (byte_len),
    .space_ok   (cnt < 4'd4),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .rd_rvalid  (rd_rvalid),
    .rsp_valid  (rsp_valid),
    .rsp_lo     (rsp_lo),
    .rsp_hi     (rsp_hi),
    .reads_done (reads_done)
  );

  txp_carry u_carry (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rsp_valid),
    .in_data  (rd_rdata),
    .in_lo    (rsp_lo),
    .in_hi    (rsp_hi),
    .pop      (fifo_wr),
    .cnt      (cnt),
    .head     (head)
  );

  assign closing    = eof_q && reads_done && (cnt != 4'd0);
  assign busy       = !reads_done || (cnt >= 4'd4) || closing;
  assign fifo_wr    = !fifo_full && ((cnt >= 4'd4) || closing);
  assign fifo_last  = fifo_wr && closing && (cnt <= 4'd4);
  assign fifo_bytes = fifo_last ? cnt[2:0] : 3'd4;

  generate
    for (genvar g = 0; g < 4; g++) begin : g_lane
      assign fifo_data[8*g +: 8] = (cnt > 4'(g)) ? head[8*g +: 8] : 8'h00;
    end
  endgenerate

  always_comb begin
    eof_d = eof_q;
    if (accept) eof_d = eof;
    else if (fifo_last) eof_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eof_q <= 1'b0;
    else        eof_q <= eof_d;
  end
endmodule

// File: rtl/txp_packer_chk.sv
module txp_packer_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic          fifo_full,
  input logic          fifo_wr,
  input logic          fifo_last,
  input logic [2:0]    fifo_bytes
);
  // R2
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> rd_addr[1:0] == 2'b00);
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));
  // R5
  full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && !fifo_last) |-> fifo_bytes == 3'd4);
  // R6
  last_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_last |-> (fifo_wr && fifo_bytes >= 3'd1 && fifo_bytes <= 3'd4));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);
endmodule

bind txp_packer txp_packer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_ack     (rd_ack),
  .fifo_full  (fifo_full),
  .fifo_wr    (fifo_wr),
  .fifo_last  (fifo_last),
  .fifo_bytes (fifo_bytes)
);

// File: tb/txp_packer_tb.sv
module txp_packer_tb;
  typedef struct packed {
    logic [31:0] d;
    logic [2:0]  n;
    logic        l;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [15:0] byte_len = '0;
  logic        eof = 1'b0;
  logic        busy, rd_req, rd_ack = 1'b0, rd_rvalid = 1'b0;
  logic [31:0] rd_addr, rd_rdata = '0;
  logic        fifo_full = 1'b0, fifo_wr, fifo_last;
  logic [31:0] fifo_data;
  logic [2:0]  fifo_bytes;

  int tests = 0, fails = 0;
  int ack_pct = 100, full_pct = 0;
  item_t       exp_q[$];
  logic [31:0] addr_q[$];
  logic [7:0]  pend[$];

  always #2 clk = ~clk;

  txp_packer u_dut (.*);

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = mem_byte(a + 32'(k));
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder and monitor: drive after posedge, sample at negedge
  initial begin
    bit hs;
    logic [31:0] hs_addr;
    hs = 1'b0;
    hs_addr = '0;
    forever begin
      @(posedge clk);
      #1;
      rd_rvalid = hs;
      rd_rdata  = hs ? mem_word(hs_addr) : 32'h0;
      rd_ack    = ($urandom_range(99, 0) < ack_pct);
      fifo_full = ($urandom_range(99, 0) < full_pct);
      @(negedge clk);
      hs = rd_req && rd_ack && rst_n;
      if (hs) begin
        hs_addr = rd_addr;
        if (addr_q.size() == 0) chk(1'b0, "R3 extra read", 64'(rd_addr), 64'hFFFF);
        else begin
          logic [31:0] ea;
          ea = addr_q.pop_front();
          chk(rd_addr == ea, "R2 read address", 64'(rd_addr), 64'(ea));
        end
      end
      if (fifo_wr && rst_n) begin
        chk(!fifo_full, "R8 write while full", 64'(fifo_full), 64'h0);
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected write", 64'(fifo_data), 64'h0);
        else begin
          item_t e, a;
          e = exp_q.pop_front();
          a = '{d: fifo_data, n: fifo_bytes, l: fifo_last};
          chk(a == e, e.l ? "R6 final word" : "R4/R5 word", 64'(a), 64'(e));
        end
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic run_buf(input logic [31:0] a, input int len, input bit e, input bit poke);
    int nw;
    wait_idle();
    nw = (int'(a[1:0]) + len + 3) / 4;
    if (len == 0) nw = 0;
    for (int i = 0; i < nw; i++) addr_q.push_back({a[31:2], 2'b00} + 32'(4 * i));
    for (int i = 0; i < len; i++) pend.push_back(mem_byte(a + 32'(i)));
    while (pend.size() > 4 || (pend.size() == 4 && !e)) begin
      item_t it;
      for (int k = 0; k < 4; k++) it.d[8*k +: 8] = pend.pop_front();
      it.n = 3'd4; it.l = 1'b0;
      exp_q.push_back(it);
    end
    if (e && pend.size() > 0) begin
      item_t it;
      it.d = '0;
      it.n = 3'(pend.size());
      it.l = 1'b1;
      for (int k = 0; pend.size() > 0; k++) it.d[8*k +: 8] = pend.pop_front();
      exp_q.push_back(it);
    end
    @(posedge clk); #1;
    start = 1'b1; start_addr = a; byte_len = 16'(len); eof = e;
    @(posedge clk); #1;
    start = 1'b0; start_addr = 32'hDEAD_BEE1; byte_len = 16'd9; eof = ~e;
    if (poke) begin
      // R10: start while busy must be ignored
      repeat (3) @(posedge clk);
      #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
    end
    wait_idle();
    repeat (2) @(negedge clk);
    chk(addr_q.size() == 0, "R3 read count", 64'(addr_q.size()), 64'h0);
    chk(exp_q.size() == 0, e ? "R6 frame drained" : "R7 words drained", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rd_req && !fifo_wr && !busy, "R1 reset outputs", 64'({rd_req, fifo_wr, busy}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!rd_req && !fifo_wr && !busy, "R1 idle after reset", 64'({rd_req, fifo_wr, busy}), 64'h0);
    // R2 R3 R4 R6: offset 2, 15 bytes, five reads from 0xFF0
    run_buf(32'h0000_0FF2, 15, 1'b1, 1'b0);
    // R5 R6: aligned, last word full
    run_buf(32'h0000_2000, 8, 1'b1, 1'b0);
    // R6: single byte at offset 3
    run_buf(32'h0000_3003, 1, 1'b1, 1'b0);
    // R7: leftover bytes carried to the next buffer
    run_buf(32'h0000_4001, 6, 1'b0, 1'b0);
    run_buf(32'h0000_5102, 5, 1'b1, 1'b0);
    // R11: zero-length closing buffer flushes the carry
    run_buf(32'h0000_6000, 3, 1'b0, 1'b0);
    run_buf(32'h0000_7003, 0, 1'b1, 1'b0);
    // R3: zero length with empty carry does nothing
    run_buf(32'h0000_7100, 0, 1'b1, 1'b0);
    // R10: start pulse during a long buffer
    run_buf(32'h0000_8001, 40, 1'b1, 1'b1);
    // R8 R9: heavy back-pressure and slow acknowledges with chained buffers
    ack_pct = 40; full_pct = 70;
    for (int i = 0; i < 30; i++) begin
      logic [31:0] a;
      a = 32'h0001_0000 + 32'($urandom_range(4095, 0));
      run_buf(a, $urandom_range(21, 1), (i % 3) == 2, 1'b0);
    end
    run_buf(32'h0002_0002, 2, 1'b1, 1'b0);
    ack_pct = 100; full_pct = 0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule